// File: doc/BRIEF.md
# Delayed-Branch Condition Control Unit

This unit makes the branch decision for a simple in-order fetch path with 16-bit instructions. It keeps one condition flag, called T here. Only compare operations write T. Unconditional, branch-if-true and branch-if-false requests are checked against T, and the unit steers the fetch address to match. Each cycle in which `issue_i` is high, one decoded operation is presented: its class, two register operands and a signed PC-relative displacement. That operation belongs to the instruction at `fetch_addr_o`. When `issue_i` is low, the issue stalls and all state holds.

An unconditional branch has one architectural delay slot. The instruction that follows the branch always issues before control moves to the target. A conditional branch that is taken goes straight to its target with no delay slot. The unit then raises a one-cycle squash pulse so that the word already fetched in sequence is dropped. A branch request that arrives in a delay slot is illegal. The unit ignores it and flags it.

The target is the address after the branch plus the sign-extended displacement times two. Instruction decode, the register file and constant loads from memory lie outside this unit.

Top module: `dslot_branch_ctl`

## Requirements
- R1: While reset is applied, and after it is released with no issue, `fetch_addr_o` equals RESET_VEC (default 0x100). `t_flag_o`, `delay_slot_o`, `squash_o` and `illegal_o` are all 0.
- R2: A class-2 operation (signed greater-or-equal compare) sets T to 1 when operand A, read as signed, is greater than or equal to operand B. Otherwise it sets T to 0. The new T is visible the cycle after the issue.
- R3: A class-1 operation (equality compare) sets T to 1 when A equals B and to 0 otherwise. The new T is visible the cycle after the issue.
- R4: Classes 0 (arithmetic and other), 3, 4, 5 (branches) and the spare codes 6 and 7 leave T unchanged.
- R5: An issued non-branch operation outside a delay slot advances `fetch_addr_o` by 2 in the next cycle. A cycle with `issue_i` low changes no output value, and both pulse outputs read 0.
- R6: A class-3 operation (unconditional branch) at address P moves the fetch address to P+2 and raises `delay_slot_o` for exactly one issue. When that slot instruction issues, the fetch address becomes P+2+2·sext(disp).
- R7: A class-4 operation (branch if T=1) or class-5 operation (branch if T=0) uses T as it stands before the branch. If the branch is taken, the next fetch address is P+2+2·sext(disp) and `squash_o` is 1 for one cycle. If it is not taken, the address becomes P+2 and `squash_o` stays 0.
- R8: A class 3, 4 or 5 operation issued while `delay_slot_o` is 1 sets `illegal_o` to 1 in the next cycle and has no effect on the flow. Control still moves to the pending target. `illegal_o` is 0 after every other issue.
- R9: A compare issued in a delay slot still updates T.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| issue_i | input | 1 | An operation issues this cycle |
| op_class_i | input | 3 | Operation class: 0 other, 1 equal compare, 2 signed ge compare, 3 branch, 4 branch if T, 5 branch if not T, 6-7 other |
| opnd_a_i | input | DATA_W | First compare operand |
| opnd_b_i | input | DATA_W | Second compare operand |
| disp_i | input | DISP_W | Signed displacement in instruction units |
| fetch_addr_o | output | ADDR_W | Address of the instruction issuing now |
| t_flag_o | output | 1 | Condition flag T |
| delay_slot_o | output | 1 | The instruction issuing now is a delay slot |
| squash_o | output | 1 | Drop the sequentially fetched word (taken conditional branch) |
| illegal_o | output | 1 | The previous issue was a branch inside a delay slot |

## Verification
The assertions assume that the operand and displacement inputs are meaningful only while `issue_i` is high. They also assume that the reset vector is an even address, so the fetch address stays aligned to 2. The stimulus drives every class code, spare codes included, and stalls about one cycle in eight. It biases operands toward equal pairs and toward signed extremes such as 0x7FFFFFFF and 0x80000000. Unconditional branches come often enough that branch requests land in delay slots on many occasions. Directed sequences cover both conditional polarities and a negative displacement.

// File: rtl/bcc_pkg.sv
package bcc_pkg;
  typedef enum logic [2:0] {
    OPC_OTHER = 3'd0,
    OPC_CMPEQ = 3'd1,
    OPC_CMPGE = 3'd2,
    OPC_JUMP  = 3'd3,
    OPC_IFT   = 3'd4,
    OPC_IFF   = 3'd5,
    OPC_SPR6  = 3'd6,
    OPC_SPR7  = 3'd7
  } opc_e;

  function automatic logic opc_is_cmp(opc_e c);
    return (c == OPC_CMPEQ) || (c == OPC_CMPGE);
  endfunction

  function automatic logic opc_is_branch(opc_e c);
    return (c == OPC_JUMP) || (c == OPC_IFT) || (c == OPC_IFF);
  endfunction
endpackage

// File: rtl/bcc_tflag.sv
module bcc_tflag
  import bcc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_i,
  input  opc_e              opc_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic              t_o
);
  logic t_q, t_d, t_en;

  always_comb begin
    t_en = issue_i && opc_is_cmp(opc_i);
    if (opc_i == OPC_CMPGE) t_d = ($signed(a_i) >= $signed(b_i));
    else                    t_d = (a_i == b_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    t_q <= 1'b0;
    else if (t_en) t_q <= t_d;
  end

  assign t_o = t_q;

  AST_T_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!issue_i || !opc_is_cmp(opc_i)) |=> $stable(t_q)); // R4
  AST_EQ_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_i && opc_i == OPC_CMPEQ && a_i == b_i) |=> t_q); // R3
  AST_GE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_i && opc_i == OPC_CMPGE && $signed(a_i) < $signed(b_i)) |=> !t_q); // R2
endmodule

// File: rtl/bcc_target.sv
module bcc_target #(
  parameter int ADDR_W = 32,
  parameter int DISP_W = 8
) (
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [DISP_W-1:0] disp_i,
  output logic [ADDR_W-1:0] seq_o,
  output logic [ADDR_W-1:0] tgt_o
);
  localparam int EXT_W = ADDR_W - DISP_W;
  localparam logic [ADDR_W-1:0] INSN_BYTES = ADDR_W'(2);

  logic [ADDR_W-1:0] disp_ext;

  always_comb begin
    disp_ext = {{EXT_W{disp_i[DISP_W-1]}}, disp_i};
    seq_o    = pc_i + INSN_BYTES;
    tgt_o    = seq_o + {disp_ext[ADDR_W-2:0], 1'b0};
  end
endmodule

// File: rtl/bcc_seq.sv
module bcc_seq
  import bcc_pkg::*;
#(
  parameter int              ADDR_W    = 32,
  parameter logic [ADDR_W-1:0] RESET_VEC = 'h100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_i,
  input  opc_e              opc_i,
  input  logic              t_i,
  input  logic [ADDR_W-1:0] seq_i,
  input  logic [ADDR_W-1:0] tgt_i,
  output logic [ADDR_W-1:0] pc_o,
  output logic              slot_o,
  output logic              squash_o,
  output logic              illegal_o
);
  logic [ADDR_W-1:0] pc_q, pc_d, pend_q, pend_d;
  logic              slot_q, slot_d, squash_q, squash_d, illegal_q, illegal_d;
  logic              take;

  always_comb begin
    pc_d      = pc_q;
    pend_d    = pend_q;
    slot_d    = slot_q;
    squash_d  = 1'b0;
    illegal_d = 1'b0;
    take      = 1'b0;
    if (issue_i) begin
      if (slot_q) begin
        pc_d      = pend_q;
        slot_d    = 1'b0;
        illegal_d = opc_is_branch(opc_i);
      end else begin
        unique case (opc_i)
          OPC_JUMP: begin
            pc_d   = seq_i;
            pend_d = tgt_i;
            slot_d = 1'b1;
          end
          OPC_IFT, OPC_IFF: begin
            take     = (opc_i == OPC_IFT) ? t_i : !t_i;
            pc_d     = take ? tgt_i : seq_i;
            squash_d = take;
          end
          default: pc_d = seq_i;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q   <= RESET_VEC;
      pend_q <= RESET_VEC;
      slot_q <= 1'b0;
    end else if (issue_i) begin
      pc_q   <= pc_d;
      pend_q <= pend_d;
      slot_q <= slot_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      squash_q  <= 1'b0;
      illegal_q <= 1'b0;
    end else begin
      squash_q  <= squash_d;
      illegal_q <= illegal_d;
    end
  end

  assign pc_o      = pc_q;
  assign slot_o    = slot_q;
  assign squash_o  = squash_q;
  assign illegal_o = illegal_q;

  AST_SLOT_AFTER_JUMP: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_i && !slot_q && opc_i == OPC_JUMP) |=> slot_q); // R6
  AST_SLOT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_i && slot_q) |=> !slot_q); // R6
  AST_ILLEGAL_IN_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_i && slot_q && opc_is_branch(opc_i)) |=> illegal_q); // R8
  AST_NO_ILLEGAL_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (!issue_i || !slot_q) |=> !illegal_q); // R8
  AST_SQUASH_NOT_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    squash_q |-> !slot_q); // R7
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_i |=> ($stable(pc_q) && $stable(slot_q) && !squash_q && !illegal_q)); // R5
  AST_PC_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    issue_i |=> (pc_q[0] == $past(pc_q[0]))); // R5
endmodule

// File: rtl/dslot_branch_ctl.sv
module dslot_branch_ctl
  import bcc_pkg::*;
#(
  parameter int                ADDR_W    = 32,
  parameter int                DATA_W    = 32,
  parameter int                DISP_W    = 8,
  parameter logic [ADDR_W-1:0] RESET_VEC = 'h100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_i,
  input  logic [2:0]        op_class_i,
  input  logic [DATA_W-1:0] opnd_a_i,
  input  logic [DATA_W-1:0] opnd_b_i,
  input  logic [DISP_W-1:0] disp_i,
  output logic [ADDR_W-1:0] fetch_addr_o,
  output logic              t_flag_o,
  output logic              delay_slot_o,
  output logic              squash_o,
  output logic              illegal_o
);
  logic              rst_meta_q, rst_sync_q;
  logic [ADDR_W-1:0] seq_addr, tgt_addr;
  opc_e              opc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  assign opc = opc_e'(op_class_i);

  bcc_tflag #(.DATA_W(DATA_W)) u_tflag (
    .clk(clk), .rst_n(rst_sync_q), .issue_i(issue_i), .opc_i(opc),
    .a_i(opnd_a_i), .b_i(opnd_b_i), .t_o(t_flag_o)
  );

  bcc_target #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_target (
    .pc_i(fetch_addr_o), .disp_i(disp_i), .seq_o(seq_addr), .tgt_o(tgt_addr)
  );

  bcc_seq #(.ADDR_W(ADDR_W), .RESET_VEC(RESET_VEC)) u_seq (
    .clk(clk), .rst_n(rst_sync_q), .issue_i(issue_i), .opc_i(opc),
    .t_i(t_flag_o), .seq_i(seq_addr), .tgt_i(tgt_addr),
    .pc_o(fetch_addr_o), .slot_o(delay_slot_o),
    .squash_o(squash_o), .illegal_o(illegal_o)
  );

  AST_RESET_VEC_EVEN: assert property (@(posedge clk) disable iff (!rst_sync_q)
    fetch_addr_o[0] == 1'b0); // R1
endmodule

// File: tb/sim_dslot_branch_ctl.sv
`timescale 1ns/1ps
module sim_dslot_branch_ctl;
  localparam int AW = 32, DW = 32, PW = 8;
  localparam logic [AW-1:0] RV = 32'h100;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          issue = 1'b0;
  logic [2:0]    cls = 3'd0;
  logic [DW-1:0] a = '0, b = '0;
  logic [PW-1:0] disp = '0;
  logic [AW-1:0] fetch;
  logic          tf, slot, squash, illegal;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  logic [AW-1:0] m_pc, m_pend;
  logic          m_t, m_slot, m_sq, m_il;
  string         tg_pc, tg_t;

  always #10 clk = ~clk;

  dslot_branch_ctl #(.ADDR_W(AW), .DATA_W(DW), .DISP_W(PW), .RESET_VEC(RV)) u0 (
    .clk(clk), .rst_n(rst_n), .issue_i(issue), .op_class_i(cls),
    .opnd_a_i(a), .opnd_b_i(b), .disp_i(disp), .fetch_addr_o(fetch),
    .t_flag_o(tf), .delay_slot_o(slot), .squash_o(squash), .illegal_o(illegal)
  );

  task automatic chk(string tag, string what, logic [AW-1:0] act, logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] tgt_of(logic [AW-1:0] pc, logic [PW-1:0] d);
    return pc + 32'd2 + ({{(AW-PW){d[PW-1]}}, d} << 1);
  endfunction

  task automatic check_all();
    chk(tg_pc, "fetch_addr", fetch, m_pc);
    chk(tg_t, "t_flag", {31'd0, tf}, {31'd0, m_t});
    chk("R6", "delay_slot", {31'd0, slot}, {31'd0, m_slot});
    chk("R7", "squash", {31'd0, squash}, {31'd0, m_sq});
    chk("R8", "illegal", {31'd0, illegal}, {31'd0, m_il});
  endtask

  // Drive at negedge; the result appears after the next posedge and is checked at the negedge after it.
  task automatic step(bit v, logic [2:0] c, logic [DW-1:0] xa, logic [DW-1:0] xb, logic [PW-1:0] xd);
    logic take;
    @(negedge clk);
    check_all();
    issue = v; cls = c; a = xa; b = xb; disp = xd;
    m_sq = 1'b0; m_il = 1'b0;
    tg_pc = "R5"; tg_t = "R4";
    if (v) begin
      if (c == 3'd2) begin m_t = ($signed(xa) >= $signed(xb)); tg_t = m_slot ? "R9" : "R2"; end
      if (c == 3'd1) begin m_t = (xa == xb); tg_t = m_slot ? "R9" : "R3"; end
      if (m_slot) begin
        m_il = (c >= 3'd3 && c <= 3'd5);
        tg_pc = m_il ? "R8" : "R6";
        m_pc = m_pend; m_slot = 1'b0;
      end else if (c == 3'd3) begin
        tg_pc = "R6";
        m_pend = tgt_of(m_pc, xd); m_pc = m_pc + 32'd2; m_slot = 1'b1;
      end else if (c == 3'd4 || c == 3'd5) begin
        tg_pc = "R7";
        take = (c == 3'd4) ? m_t : !m_t;
        m_sq = take;
        m_pc = take ? tgt_of(m_pc, xd) : m_pc + 32'd2;
      end else begin
        m_pc = m_pc + 32'd2;
      end
    end
  endtask

  function automatic logic [DW-1:0] pick();
    case ($urandom % 6)
      0: return 32'h7fff_ffff;
      1: return 32'h8000_0000;
      2: return 32'h0;
      3: return 32'hffff_ffff;
      default: return $urandom;
    endcase
  endfunction

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    m_pc = RV; m_pend = RV; m_t = 1'b0; m_slot = 1'b0; m_sq = 1'b0; m_il = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    tg_pc = "R1"; tg_t = "R1";
    check_all();                       // R1 during reset
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    tg_pc = "R1"; tg_t = "R1";
    check_all();                       // R1 after release
    // directed corner cases
    step(1, 3'd0, 0, 0, 0);            // R5 sequential
    step(0, 3'd3, 0, 0, 8'h05);        // R5 stall ignores a jump
    step(1, 3'd2, 32'hffff_ffff, 32'd1, 0); // R2 -1 >= 1 false
    step(1, 3'd5, 0, 0, 8'h04);        // R7 branch-if-false taken
    step(1, 3'd1, 32'h1234, 32'h1234, 0);   // R3 equal
    step(1, 3'd0, 1, 2, 0);            // R4 add keeps T
    step(1, 3'd4, 0, 0, 8'hfd);        // R7 branch-if-true taken, negative disp
    step(1, 3'd5, 0, 0, 8'h10);        // R7 not taken
    step(1, 3'd3, 0, 0, 8'hfd);        // R6 jump back
    step(1, 3'd4, 0, 0, 8'h20);        // R8 branch in slot ignored
    step(1, 3'd2, 32'h8000_0000, 32'h7fff_ffff, 0); // R2 min < max
    step(1, 3'd3, 0, 0, 8'h7f);        // R6 jump
    step(1, 3'd1, 5, 5, 0);            // R9 compare in slot
    step(1, 3'd6, 0, 0, 0);            // R4 spare code
    step(1, 3'd3, 0, 0, 8'h02);        // R6
    step(0, 3'd0, 0, 0, 0);            // R5 stall inside slot
    step(1, 3'd3, 0, 0, 8'h40);        // R8 jump in slot
    for (int i = 0; i < 3000; i++) begin
      logic [DW-1:0] ra;
      ra = pick();
      step(($urandom % 8) != 0, 3'($urandom % 8), ra,
           (($urandom % 4) == 0) ? ra : pick(), 8'($urandom));
    end
    step(0, 3'd0, 0, 0, 0);
    @(negedge clk);
    check_all();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule